// File: doc/BRIEF.md
# Result Bus Reservation Scheduler

This block decides, at the moment an instruction is sent to a functional unit, in which cycle that unit may drive the shared result bus. Units have fixed latencies from 1 to `NSTAGE` cycles. The scheduler keeps a chain of `NSTAGE` slots. Slot k stands for "the result bus is taken k cycles from now". An instruction that needs i cycles claims slot i. The claim carries the unit number and the reorder-buffer tag. Every clock all claims move one slot closer to the bus. The claim that leaves the nearest slot becomes the registered bus grant, together with the unit number and the tag. Because collisions are settled when the instruction is issued, writeback needs no arbiter.

The issue side holds a request until `iss_ready` rises. The check and the shift happen in the same cycle. A request for latency i therefore looks at the slot that will be at position i after the shift, which is the current slot i+1. A latency of `NSTAGE` can always be accepted. On a squash, claims whose tag is younger than a given point are dropped. Youth is measured as the distance from the reorder-buffer head. A second flag drops every claim.

Top module: `rsr_sched`

## Requirements
- R1: After reset `bus_grant` is low and every slot is empty, so the first request of any valid latency is accepted without waiting.
- R2: A request with latency 0 or above `NSTAGE` raises `iss_err` in the same cycle, is never accepted, and never produces a bus grant.
- R3: A request accepted at a clock edge with latency i shows `bus_grant` high with its unit and tag during the cycle that follows the i-th edge after the accepting edge.
- R4: A request for latency i < `NSTAGE` is held (`iss_ready` low) while current slot i+1 holds a claim. It is accepted on a later cycle once that slot is free.
- R5: A request for latency `NSTAGE` is never held because of occupancy.
- R6: Accepted requests of mixed latencies each get the bus in exactly one cycle. At most one grant is given per cycle, in order of completion time rather than issue order.
- R7: With `flush_valid` high and `flush_all` low, a claim whose age is greater than the age of `flush_tag` is dropped. The age of a tag is (tag − `rob_head`) mod 2^5. The claim of `flush_tag` itself and older claims still reach the bus.
- R8: With `flush_valid` and `flush_all` high, all claims, including the one due on the next cycle, are dropped.
- R9: No request is accepted in a cycle where `flush_valid` is high.
- R10: While `bus_grant` is low, `bus_unit` and `bus_tag` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request present |
| iss_lat | input | LAT_W (3) | Latency of the requesting unit, 1..NSTAGE |
| iss_unit | input | 3 | Functional-unit number |
| iss_tag | input | 5 | Reorder-buffer tag of the instruction |
| iss_ready | output | 1 | Request accepted at the coming edge |
| iss_err | output | 1 | Requested latency out of range |
| flush_valid | input | 1 | Squash this cycle |
| flush_all | input | 1 | Squash every claim |
| flush_tag | input | 5 | Squash point; younger tags are dropped |
| rob_head | input | 5 | Oldest reorder-buffer tag, used for age |
| bus_grant | output | 1 | Result bus granted this cycle |
| bus_unit | output | 3 | Unit that owns the bus |
| bus_tag | output | 5 | Tag that steers the result into the reorder buffer |

## Verification
Several properties are checked on every cycle:
- error and acceptance are exclusive, and a squash cycle never accepts;
- an occupied next slot holds the request, and the farthest latency is never held;
- an accepted claim sits in its slot on the next cycle, and a latency-1 claim appears on the bus two edges later;
- a full squash silences the bus for two cycles;
- the idle bus reads zero.

Only the scenarios can show whole delivery timing for longer latencies. They also show which tags survive a selective squash when the tag space wraps around the head, and the exact number of retry cycles a conflict costs. A scoreboard compares these against the grant sequence.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

    localparam int UNIT_W = 3;
    localparam int TAG_W  = 5;

    typedef logic [UNIT_W-1:0] unit_t;
    typedef logic [TAG_W-1:0]  tag_t;

    // One reservation: an empty slot is all zeros
    typedef struct packed {
        logic  vld;
        unit_t unit;
        tag_t  tag;
    } rsv_t;

    // Distance of a tag from the oldest in-flight tag
    function automatic tag_t rob_age(input tag_t tag, input tag_t head);
        return tag_t'(tag - head);
    endfunction

    function automatic logic is_younger(input tag_t tag, input tag_t point, input tag_t head);
        return rob_age(tag, head) > rob_age(point, head);
    endfunction

endpackage

// File: rtl/rsr_issue_ctl.sv
module rsr_issue_ctl
    import rsr_pkg::*;
#(
    parameter int N     = 6,
    parameter int LAT_W = $clog2(N + 1)
) (
    input  logic             req_valid,
    input  logic [LAT_W-1:0] req_lat,
    input  logic             hold,
    input  logic [N-1:0]     occ,
    output logic [N-1:0]     slot_sel,
    output logic             grant,
    output logic             bad
);

    logic [N-1:0] lat_hit;
    logic [N-1:0] slot_free;

    for (genvar k = 0; k < N; k++) begin : g_slot
        assign lat_hit[k] = (req_lat == LAT_W'(k + 1));
        if (k == N - 1) begin : g_far
            // nothing shifts into the farthest slot
            assign slot_free[k] = 1'b1;
        end else begin : g_near
            // after the shift, slot k receives what is now in slot k+1
            assign slot_free[k] = !occ[k + 1];
        end
        assign slot_sel[k] = req_valid && !hold && lat_hit[k] && slot_free[k];
    end

    assign grant = |slot_sel;
    assign bad   = req_valid && !(|lat_hit);

endmodule

// File: rtl/rsr_squash.sv
module rsr_squash
    import rsr_pkg::*;
#(
    parameter int N = 6
) (
    input  rsv_t [N-1:0] st,
    input  logic         flush_valid,
    input  logic         flush_all,
    input  tag_t         flush_tag,
    input  tag_t         rob_head,
    output logic [N-1:0] kill
);

    for (genvar k = 0; k < N; k++) begin : g_kill
        assign kill[k] = flush_valid &&
                         (flush_all || is_younger(st[k].tag, flush_tag, rob_head));
    end

endmodule

// File: rtl/rsr_stage_chain.sv
module rsr_stage_chain
    import rsr_pkg::*;
#(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] slot_sel,
    input  rsv_t         new_ent,
    input  logic [N-1:0] kill,
    output rsv_t [N-1:0] st_q,
    output rsv_t         bus_q
);

    rsv_t [N-1:0] st_d;
    rsv_t         bus_d;

    for (genvar k = 0; k < N; k++) begin : g_next
        rsv_t shifted;
        if (k == N - 1) begin : g_far
            assign shifted = '0;
        end else begin : g_near
            assign shifted = kill[k + 1] ? '0 : st_q[k + 1];
        end
        assign st_d[k] = slot_sel[k] ? new_ent : shifted;
    end

    // slot 1 leaves the chain and owns the bus for one cycle
    assign bus_d = kill[0] ? '0 : st_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            bus_q <= '0;
        end else begin
            st_q  <= st_d;
            bus_q <= bus_d;
        end
    end

endmodule

// File: rtl/rsr_sched.sv
module rsr_sched
    import rsr_pkg::*;
#(
    parameter int NSTAGE = 6,
    parameter int LAT_W  = $clog2(NSTAGE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_valid,
    input  logic [LAT_W-1:0] iss_lat,
    input  logic [2:0]       iss_unit,
    input  logic [4:0]       iss_tag,
    output logic             iss_ready,
    output logic             iss_err,
    input  logic             flush_valid,
    input  logic             flush_all,
    input  logic [4:0]       flush_tag,
    input  logic [4:0]       rob_head,
    output logic             bus_grant,
    output logic [2:0]       bus_unit,
    output logic [4:0]       bus_tag
);

    rsv_t [NSTAGE-1:0] st_q;
    rsv_t              bus_q;
    rsv_t              new_ent;
    logic [NSTAGE-1:0] occ_vec;
    logic [NSTAGE-1:0] slot_sel;
    logic [NSTAGE-1:0] kill;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_occ
        assign occ_vec[k] = st_q[k].vld;
    end

    assign new_ent = '{vld: 1'b1, unit: unit_t'(iss_unit), tag: tag_t'(iss_tag)};

    rsr_issue_ctl #(.N(NSTAGE), .LAT_W(LAT_W)) u_issue (
        .req_valid (iss_valid),
        .req_lat   (iss_lat),
        .hold      (flush_valid),
        .occ       (occ_vec),
        .slot_sel  (slot_sel),
        .grant     (iss_ready),
        .bad       (iss_err)
    );

    rsr_squash #(.N(NSTAGE)) u_squash (
        .st          (st_q),
        .flush_valid (flush_valid),
        .flush_all   (flush_all),
        .flush_tag   (tag_t'(flush_tag)),
        .rob_head    (tag_t'(rob_head)),
        .kill        (kill)
    );

    rsr_stage_chain #(.N(NSTAGE)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .slot_sel (slot_sel),
        .new_ent  (new_ent),
        .kill     (kill),
        .st_q     (st_q),
        .bus_q    (bus_q)
    );

    assign bus_grant = bus_q.vld;
    assign bus_unit  = 3'(bus_q.unit);
    assign bus_tag   = 5'(bus_q.tag);

endmodule

// File: rtl/rsr_sched_chk.sv
module rsr_sched_chk #(
    parameter int N     = 6,
    parameter int LAT_W = $clog2(N + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             iss_valid,
    input logic [LAT_W-1:0] iss_lat,
    input logic [4:0]       iss_tag,
    input logic             iss_ready,
    input logic             iss_err,
    input logic             flush_valid,
    input logic             flush_all,
    input logic             bus_grant,
    input logic [2:0]       bus_unit,
    input logic [4:0]       bus_tag,
    input logic [N-1:0]     occ
);

    assert_err_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        iss_err |-> !iss_ready);

    assert_no_issue_in_flush_R9: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> !iss_ready);

    assert_claim_lands_R3: assert property (@(posedge clk) disable iff (rst)
        iss_ready |=> occ[$past(iss_lat) - LAT_W'(1)]);

    assert_lat1_delivery_R3: assert property (@(posedge clk) disable iff (rst)
        (iss_ready && iss_lat == LAT_W'(1)) ##1 !flush_valid
        |=> bus_grant && bus_tag == $past(iss_tag, 2));

    assert_conflict_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_err && iss_lat < LAT_W'(N) && occ[iss_lat]) |-> !iss_ready);

    assert_far_never_held_R5: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_lat == LAT_W'(N) && !flush_valid) |-> iss_ready);

    assert_bus_from_slot1_R6: assert property (@(posedge clk) disable iff (rst)
        bus_grant |-> $past(occ[0]));

    assert_full_flush_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && flush_all) |=> !bus_grant ##1 !bus_grant);

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_grant |-> (bus_unit == 3'd0 && bus_tag == 5'd0));

endmodule

bind rsr_sched rsr_sched_chk #(.N(NSTAGE), .LAT_W(LAT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .iss_valid   (iss_valid),
    .iss_lat     (iss_lat),
    .iss_tag     (iss_tag),
    .iss_ready   (iss_ready),
    .iss_err     (iss_err),
    .flush_valid (flush_valid),
    .flush_all   (flush_all),
    .bus_grant   (bus_grant),
    .bus_unit    (bus_unit),
    .bus_tag     (bus_tag),
    .occ         (occ_vec)
);

// File: tb/tb_rsr_sched.sv
module tb_rsr_sched;

    localparam int NS = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iss_valid = 1'b0;
    logic [2:0] iss_lat = '0;
    logic [2:0] iss_unit = '0;
    logic [4:0] iss_tag = '0;
    logic       iss_ready, iss_err;
    logic       flush_valid = 1'b0, flush_all = 1'b0;
    logic [4:0] flush_tag = '0, rob_head = '0;
    logic       bus_grant;
    logic [2:0] bus_unit;
    logic [4:0] bus_tag;

    typedef struct {
        int due;
        int unit;
        int tag;
    } exp_t;

    exp_t  q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    mon_on = 1'b0;
    string cur_req = "R3";

    always #4 clk = ~clk;

    rsr_sched dut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_lat(iss_lat), .iss_unit(iss_unit), .iss_tag(iss_tag),
        .iss_ready(iss_ready), .iss_err(iss_err),
        .flush_valid(flush_valid), .flush_all(flush_all),
        .flush_tag(flush_tag), .rob_head(rob_head),
        .bus_grant(bus_grant), .bus_unit(bus_unit), .bus_tag(bus_tag)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int age(input int tag, input int head);
        return (tag - head) & 31;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compares every bus cycle with the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            int hit;
            hit = -1;
            foreach (q[i]) begin
                if (q[i].due == cyc) hit = i;
                if (q[i].due < cyc)
                    check(1'b0, cur_req, "missed grant tag", q[i].tag, q[i].due);
            end
            if (hit >= 0) begin
                check(bus_grant == 1'b1, cur_req, "grant", int'(bus_grant), 1);
                check(int'(bus_tag) == q[hit].tag, cur_req, "bus tag", int'(bus_tag), q[hit].tag);
                check(int'(bus_unit) == q[hit].unit, cur_req, "bus unit", int'(bus_unit), q[hit].unit);
                q.delete(hit);
            end else begin
                check(bus_grant == 1'b0, cur_req, "unexpected grant", int'(bus_grant), 0);
                check(bus_unit == 3'd0 && bus_tag == 5'd0, "R10", "idle bus fields",
                      int'({bus_unit, bus_tag}), 0);
            end
        end
    end

    // Driver: holds a request until accepted, then records its due cycle
    task automatic issue(input int lat, input int unit, input int tag, output int stalls);
        @(negedge clk);
        iss_valid = 1'b1;
        iss_lat   = 3'(lat);
        iss_unit  = 3'(unit);
        iss_tag   = 5'(tag);
        stalls    = 0;
        #1;
        while (!iss_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        q.push_back('{cyc + 1 + lat, unit, tag});
        @(posedge clk);
        #1 iss_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic squash(input bit all, input int ftag, input int head, input bit try_issue);
        @(negedge clk);
        flush_valid = 1'b1;
        flush_all   = all;
        flush_tag   = 5'(ftag);
        rob_head    = 5'(head);
        if (try_issue) begin
            iss_valid = 1'b1;
            iss_lat   = 3'd3;
            iss_unit  = 3'd7;
            iss_tag   = 5'd17;
        end
        #1;
        if (try_issue) check(iss_ready == 1'b0, "R9", "ready during flush", int'(iss_ready), 0);
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due >= cyc + 1 && (all || age(q[i].tag, head) > age(ftag, head)))
                q.delete(i);
        end
        @(posedge clk);
        #1;
        flush_valid = 1'b0;
        flush_all   = 1'b0;
        iss_valid   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(bus_grant == 1'b0, "R1", "grant after reset", int'(bus_grant), 0);
        mon_on = 1'b1;

        // R1 / R3: first requests, single latencies
        cur_req = "R3";
        issue(1, 1, 3, s);
        check(s == 0, "R1", "stalls on empty chain", s, 0);
        idle(3);
        issue(3, 2, 4, s);
        idle(5);
        issue(NS, 5, 6, s);
        idle(8);

        // R2: out-of-range latencies
        @(negedge clk);
        iss_valid = 1'b1; iss_lat = 3'd0; iss_tag = 5'd9; #1;
        check(iss_err == 1'b1, "R2", "err for latency 0", int'(iss_err), 1);
        check(iss_ready == 1'b0, "R2", "ready for latency 0", int'(iss_ready), 0);
        @(negedge clk);
        iss_lat = 3'd7; #1;
        check(iss_err == 1'b1, "R2", "err for latency 7", int'(iss_err), 1);
        check(iss_ready == 1'b0, "R2", "ready for latency 7", int'(iss_ready), 0);
        @(negedge clk);
        iss_valid = 1'b0;
        cur_req = "R2";
        idle(9);

        // R4: conflict then retry
        cur_req = "R4";
        issue(3, 3, 10, s);
        issue(2, 4, 11, s);
        check(s == 1, "R4", "retry cycles", s, 1);
        idle(8);

        // R5: farthest latency back to back
        cur_req = "R5";
        for (int k = 0; k < 6; k++) begin
            issue(NS, k, 12 + k, s);
            check(s == 0, "R5", "stall on farthest slot", s, 0);
        end
        idle(8);

        // R6: mixed latencies, completion order differs from issue order
        cur_req = "R6";
        issue(5, 1, 20, s);
        issue(1, 2, 21, s);
        issue(2, 3, 22, s);
        issue(4, 4, 23, s);
        issue(1, 5, 24, s);
        idle(10);

        // R7: selective squash, plain and wrapped around the head
        cur_req = "R7";
        issue(NS, 1, 2, s);
        issue(NS, 2, 5, s);
        issue(NS, 3, 9, s);
        squash(1'b0, 5, 0, 1'b0);
        idle(9);
        issue(NS, 1, 30, s);
        issue(NS, 2, 1, s);
        issue(NS, 3, 29, s);
        squash(1'b0, 31, 28, 1'b0);
        idle(9);

        // R8 / R9: full squash with a request pending
        cur_req = "R8";
        issue(4, 1, 3, s);
        issue(5, 2, 4, s);
        issue(NS, 3, 5, s);
        issue(2, 4, 6, s);
        squash(1'b1, 0, 0, 1'b1);
        idle(9);

        check(q.size() == 0, "R3", "undelivered entries", q.size(), 0);
        mon_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule